// File: doc/BRIEF.md
# Comparator-Driven Clock Interrupt Emulator

This block turns one one-shot comparator, placed next to a free-running counter, into the three interrupt sources of a real-time clock: a seconds-update event, a time-of-day alarm and a periodic tick. When the counter reaches the comparator, the block moves the comparator forward by one period per clock cycle until the comparator is ahead of the counter again. Each period it had to skip is recorded as a lost tick. It then sets the flags that apply and presents them as a status word for one cycle.

The periodic tick comes from a base rate of 64 Hz. Slower requested rates divide that base rate with a per-event counter. Faster rates replace the period with the counter-tick length of one requested period. The seconds and the alarm are checked against an hours/minutes/seconds value supplied from outside the block, which does not keep time itself.

Top module: `tick_alarm_engine`

## Requirements
- R1: After reset, `armed_o`, `busy_o` and `stat_vld_o` are 0, and `cmp_o`, `status_o` and `lost_o` are zero.
- R2: Mode enables are `en_i[0]` for update, `en_i[1]` for alarm and `en_i[2]` for periodic. When `en_i` goes from all-zero to non-zero, the next cycle shows `armed_o`=1 and `cmp_o` = counter + period. The period defaults to TICKS_PER_SEC/64.
- R3: The comparator c is ahead of the counter n when bit 31 of (n − c) is set, which is the wrap-safe signed test. A match happens only when the comparator is armed and not ahead.
- R4: On a match, the block adds the period to the comparator once per cycle with `busy_o` high. It stops when the comparator is ahead. `lost_o` then reports the number of adds minus one.
- R5: A periodic rate f of 64 Hz or less uses the default period with a divide limit of 64/f. The periodic flag rises on the event where the periodic count reaches the limit, and the count then clears.
- R6: A periodic rate f above 64 Hz uses the period TICKS_PER_SEC/f and a limit of 1.
- R7: With periodic mode on, each event adds its lost ticks plus one to the periodic count.
- R8: The update flag rises on an event whose seconds differ from the last recorded seconds. The first event after update mode is newly enabled only records the seconds.
- R9: The alarm flag rises on an event where hours, minutes and seconds all equal the alarm time loaded with `alm_wr_i`.
- R10: The status word is valid for one cycle with `stat_vld_o`. Its fields are: bit 4 update, bit 5 alarm, bit 6 periodic, bit 7 pending, bits 15:8 equal to 1, and bits 3:0 zero. It is all-zero when no flag is set.
- R11: With `en_i` all-zero, the channel is disarmed: no catch-up and no status, and `cmp_o` is unchanged even when the counter passes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_i | input | 32 | Free-running counter value |
| en_i | input | 3 | Mode enables (update, alarm, periodic) |
| freq_wr_i | input | 1 | Load a periodic rate |
| freq_i | input | 16 | Requested periodic rate in Hz |
| alm_wr_i | input | 1 | Load the alarm time |
| alm_hh_i | input | 5 | Alarm hours |
| alm_mm_i | input | 6 | Alarm minutes |
| alm_ss_i | input | 6 | Alarm seconds |
| cur_hh_i | input | 5 | Current hours |
| cur_mm_i | input | 6 | Current minutes |
| cur_ss_i | input | 6 | Current seconds |
| cmp_o | output | 32 | Comparator value |
| armed_o | output | 1 | Comparator channel enabled |
| busy_o | output | 1 | Catch-up in progress |
| lost_o | output | 16 | Lost ticks of the last event |
| status_o | output | 16 | Flag word |
| stat_vld_o | output | 1 | Flag word valid |

## Verification
Every cycle, the assertions check the following:
- a catch-up never runs on a disarmed channel;
- each catch-up ends with the comparator ahead of the counter in the wrap-safe sense;
- a status word appears only on the cycle after a catch-up ends, always with its fixed count and pending fields, and is zero otherwise.

Some properties can only be shown by the bench scenarios, because they depend on the history of stimulus:
- the exact number of lost ticks after a stalled counter;
- the divide limit for each requested rate;
- the silent first seconds change after update mode is enabled;
- the alarm comparison.

// File: rtl/tae_pkg.sv
package tae_pkg;
    localparam int MODE_UPD = 0;
    localparam int MODE_ALM = 1;
    localparam int MODE_PER = 2;
    localparam int MODE_N   = 3;

    localparam int ST_UF  = 4;
    localparam int ST_AF  = 5;
    localparam int ST_PF  = 6;
    localparam int ST_IRQ = 7;

    typedef struct packed {
        logic [4:0] hh;
        logic [5:0] mm;
        logic [5:0] ss;
    } tae_hms_t;
endpackage

// File: rtl/tae_wrap_cmp.sv
module tae_wrap_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] lead_i,
    input  logic [W-1:0] ref_i,
    output logic         ahead_o
);
    logic [W-1:0] gap;
    always_comb begin
        gap     = ref_i - lead_i;
        ahead_o = gap[W-1];
    end
endmodule

// File: rtl/tae_rate_calc.sv
module tae_rate_calc #(
    parameter int CNT_W         = 32,
    parameter int FREQ_W        = 16,
    parameter int LIM_W         = 7,
    parameter int BASE_SHIFT    = 6,
    parameter int TICKS_PER_SEC = 6400
) (
    input  logic [FREQ_W-1:0] freq_i,
    output logic              hi_o,
    output logic [LIM_W-1:0]  limit_o,
    output logic [CNT_W-1:0]  delta_o
);
    localparam int BASE_HZ = 1 << BASE_SHIFT;

    logic [FREQ_W-1:0] f_safe;
    logic [FREQ_W-1:0] base_c;
    logic [FREQ_W-1:0] quot;
    logic [CNT_W-1:0]  tps_c;

    always_comb begin
        f_safe  = (freq_i == '0) ? FREQ_W'(1) : freq_i;
        base_c  = FREQ_W'(BASE_HZ);
        tps_c   = CNT_W'(TICKS_PER_SEC);
        hi_o    = (f_safe > base_c);
        quot    = base_c / f_safe;
        limit_o = hi_o ? LIM_W'(1) : quot[LIM_W-1:0];
        delta_o = tps_c / {{(CNT_W-FREQ_W){1'b0}}, f_safe};
    end
endmodule

// File: rtl/tae_flag_eval.sv
module tae_flag_eval #(
    parameter int LOST_W = 16,
    parameter int LIM_W  = 7
) (
    input  logic [tae_pkg::MODE_N-1:0] en_i,
    input  tae_pkg::tae_hms_t          cur_i,
    input  tae_pkg::tae_hms_t          alm_i,
    input  logic [5:0]                 prev_sec_i,
    input  logic                       prev_vld_i,
    input  logic [LOST_W-1:0]          pie_i,
    input  logic [LOST_W-1:0]          lost_i,
    input  logic [LIM_W-1:0]           limit_i,
    output logic                       uf_o,
    output logic                       af_o,
    output logic                       pf_o,
    output logic [LOST_W-1:0]          pie_o,
    output logic [5:0]                 prev_sec_o,
    output logic                       prev_vld_o
);
    import tae_pkg::*;

    logic [LOST_W-1:0] pie_sum;

    always_comb begin
        uf_o       = 1'b0;
        pf_o       = 1'b0;
        pie_o      = pie_i;
        prev_sec_o = prev_sec_i;
        prev_vld_o = prev_vld_i;
        pie_sum    = pie_i + lost_i + LOST_W'(1);

        if (en_i[MODE_PER]) begin
            if (pie_sum >= LOST_W'(limit_i)) begin
                pf_o  = 1'b1;
                pie_o = '0;
            end else begin
                pie_o = pie_sum;
            end
        end

        if (en_i[MODE_UPD] && (!prev_vld_i || cur_i.ss != prev_sec_i)) begin
            uf_o       = prev_vld_i;
            prev_sec_o = cur_i.ss;
            prev_vld_o = 1'b1;
        end

        af_o = en_i[MODE_ALM] && (cur_i == alm_i);
    end
endmodule

// File: rtl/tick_alarm_engine.sv
module tick_alarm_engine #(
    parameter int CNT_W         = 32,
    parameter int FREQ_W        = 16,
    parameter int LOST_W        = 16,
    parameter int BASE_SHIFT    = 6,
    parameter int TICKS_PER_SEC = 6400
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           cnt_i,
    input  logic [tae_pkg::MODE_N-1:0] en_i,
    input  logic                       freq_wr_i,
    input  logic [FREQ_W-1:0]          freq_i,
    input  logic                       alm_wr_i,
    input  logic [4:0]                 alm_hh_i,
    input  logic [5:0]                 alm_mm_i,
    input  logic [5:0]                 alm_ss_i,
    input  logic [4:0]                 cur_hh_i,
    input  logic [5:0]                 cur_mm_i,
    input  logic [5:0]                 cur_ss_i,
    output logic [CNT_W-1:0]           cmp_o,
    output logic                       armed_o,
    output logic                       busy_o,
    output logic [LOST_W-1:0]          lost_o,
    output logic [15:0]                status_o,
    output logic                       stat_vld_o
);
    import tae_pkg::*;

    localparam int LIM_W   = BASE_SHIFT + 1;
    localparam int BASE_HZ = 1 << BASE_SHIFT;
    localparam logic [CNT_W-1:0] DEF_DELTA = CNT_W'(TICKS_PER_SEC >> BASE_SHIFT);

    typedef struct packed {
        logic [CNT_W-1:0]  cmp;
        logic              armed;
        logic              busy;
        logic [LOST_W-1:0] lost;
        logic [LOST_W-1:0] lost_out;
        logic [LOST_W-1:0] pie;
        logic [LIM_W-1:0]  limit;
        logic              hi;
        logic [CNT_W-1:0]  pie_delta;
        logic [MODE_N-1:0] en;
        tae_hms_t          alarm;
        logic [5:0]        prev_sec;
        logic              prev_vld;
        logic [15:0]       status;
        logic              stat_vld;
    } state_t;

    state_t s_q, s_d;

    logic              ahead_w;
    logic              hi_w;
    logic [LIM_W-1:0]  limit_w;
    logic [CNT_W-1:0]  delta_w;
    logic [CNT_W-1:0]  eff_delta;
    logic              upd_new;
    logic              uf_w, af_w, pf_w;
    logic [LOST_W-1:0] pie_w;
    logic [5:0]        prev_sec_w;
    logic              prev_vld_w;
    tae_hms_t          cur_w;

    assign cur_w = '{hh: cur_hh_i, mm: cur_mm_i, ss: cur_ss_i};

    tae_wrap_cmp #(.W(CNT_W)) u_ahead (
        .lead_i (s_q.cmp),
        .ref_i  (cnt_i),
        .ahead_o(ahead_w)
    );

    tae_rate_calc #(
        .CNT_W(CNT_W), .FREQ_W(FREQ_W), .LIM_W(LIM_W),
        .BASE_SHIFT(BASE_SHIFT), .TICKS_PER_SEC(TICKS_PER_SEC)
    ) u_rate (
        .freq_i (freq_i),
        .hi_o   (hi_w),
        .limit_o(limit_w),
        .delta_o(delta_w)
    );

    tae_flag_eval #(.LOST_W(LOST_W), .LIM_W(LIM_W)) u_flags (
        .en_i      (s_q.en),
        .cur_i     (cur_w),
        .alm_i     (s_q.alarm),
        .prev_sec_i(s_q.prev_sec),
        .prev_vld_i(s_q.prev_vld && !upd_new),
        .pie_i     (s_q.pie),
        .lost_i    (s_q.lost),
        .limit_i   (s_q.limit),
        .uf_o      (uf_w),
        .af_o      (af_w),
        .pf_o      (pf_w),
        .pie_o     (pie_w),
        .prev_sec_o(prev_sec_w),
        .prev_vld_o(prev_vld_w)
    );

    always_comb begin
        s_d          = s_q;
        s_d.stat_vld = 1'b0;
        s_d.status   = '0;
        s_d.en       = en_i;
        upd_new      = en_i[MODE_UPD] && !s_q.en[MODE_UPD];
        eff_delta    = (en_i[MODE_PER] && s_q.hi) ? s_q.pie_delta : DEF_DELTA;

        if (freq_wr_i) begin
            s_d.limit     = limit_w;
            s_d.hi        = hi_w;
            s_d.pie_delta = delta_w;
            s_d.pie       = '0;
        end
        if (alm_wr_i) begin
            s_d.alarm = '{hh: alm_hh_i, mm: alm_mm_i, ss: alm_ss_i};
        end

        if (en_i == '0) begin
            s_d.armed = 1'b0;
            s_d.busy  = 1'b0;
        end else begin
            if (upd_new) s_d.prev_vld = 1'b0;
            if (s_q.en == '0) begin
                s_d.armed = 1'b1;
                s_d.busy  = 1'b0;
                s_d.cmp   = cnt_i + eff_delta;
            end else if (s_q.busy) begin
                if (ahead_w) begin
                    s_d.busy     = 1'b0;
                    s_d.lost_out = s_q.lost;
                    s_d.prev_sec = prev_sec_w;
                    s_d.prev_vld = prev_vld_w;
                    if (s_q.en[MODE_PER]) s_d.pie = pie_w;
                    if (uf_w || af_w || pf_w) begin
                        s_d.stat_vld = 1'b1;
                        s_d.status   = {8'd1, 1'b1, pf_w, af_w, uf_w, 4'b0000};
                    end
                end else begin
                    s_d.cmp  = s_q.cmp + eff_delta;
                    s_d.lost = s_q.lost + LOST_W'(1);
                end
            end else if (s_q.armed && !ahead_w) begin
                s_d.busy = 1'b1;
                s_d.cmp  = s_q.cmp + eff_delta;
                s_d.lost = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.limit     <= LIM_W'(BASE_HZ);
            s_q.pie_delta <= DEF_DELTA;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmp_o      = s_q.cmp;
    assign armed_o    = s_q.armed;
    assign busy_o     = s_q.busy;
    assign lost_o     = s_q.lost_out;
    assign status_o   = s_q.status;
    assign stat_vld_o = s_q.stat_vld;
endmodule

// File: rtl/tae_checker.sv
module tae_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] cmp_o,
    input logic             armed_o,
    input logic             busy_o,
    input logic [15:0]      status_o,
    input logic             stat_vld_o
);
    logic [CNT_W-1:0] cnt_prev_q;
    logic [CNT_W-1:0] gap_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_prev_q <= '0;
        else        cnt_prev_q <= cnt_i;
    end
    assign gap_w = cnt_prev_q - cmp_o;

    a_r11_busy_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_o |-> !busy_o);

    a_r4_done_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> gap_w[CNT_W-1]);

    a_r4_status_after_catchup: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld_o |-> $fell(busy_o));

    a_r10_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld_o |-> (status_o[15:8] == 8'd1 && status_o[7] &&
                        (|status_o[6:4]) && status_o[3:0] == 4'd0));

    a_r10_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_vld_o |-> status_o == 16'd0);
endmodule

bind tick_alarm_engine tae_checker #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (cnt_i),
    .cmp_o     (cmp_o),
    .armed_o   (armed_o),
    .busy_o    (busy_o),
    .status_o  (status_o),
    .stat_vld_o(stat_vld_o)
);

// File: tb/tick_alarm_engine_tb_top.sv
module tick_alarm_engine_tb_top;
    localparam int CLK_P = 10;
    localparam int TPS   = 6400;
    localparam int DEF_D = TPS / 64;
    localparam int NTBL  = 5;
    localparam int FREQ_TBL [NTBL] = '{1, 8, 16, 32, 64};
    localparam int LIM_TBL  [NTBL] = '{64, 8, 4, 2, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cnt_i = '0;
    logic [2:0]  en_i = '0;
    logic        freq_wr_i = 1'b0;
    logic [15:0] freq_i = '0;
    logic        alm_wr_i = 1'b0;
    logic [4:0]  alm_hh_i = '0;
    logic [5:0]  alm_mm_i = '0, alm_ss_i = '0;
    logic [4:0]  cur_hh_i = '0;
    logic [5:0]  cur_mm_i = '0, cur_ss_i = '0;
    logic [31:0] cmp_o;
    logic        armed_o, busy_o, stat_vld_o;
    logic [15:0] lost_o, status_o;

    int checks = 0, failures = 0;
    int d = DEF_D, lim = 64, pie = 0;
    bit hi = 0, prev_v = 0;
    int prev_ss = 0;
    logic [31:0] exp_cmp = '0;
    logic [16:0] alm_t = '0;

    always #(CLK_P/2) clk = ~clk;

    tick_alarm_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .en_i(en_i),
        .freq_wr_i(freq_wr_i), .freq_i(freq_i),
        .alm_wr_i(alm_wr_i), .alm_hh_i(alm_hh_i), .alm_mm_i(alm_mm_i), .alm_ss_i(alm_ss_i),
        .cur_hh_i(cur_hh_i), .cur_mm_i(cur_mm_i), .cur_ss_i(cur_ss_i),
        .cmp_o(cmp_o), .armed_o(armed_o), .busy_o(busy_o), .lost_o(lost_o),
        .status_o(status_o), .stat_vld_o(stat_vld_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_freq(input int f);
        freq_i = 16'(f); freq_wr_i = 1'b1;
        tick();
        freq_wr_i = 1'b0;
        hi  = (f > 64);
        lim = hi ? 1 : 64 / f;
        pie = 0;
    endtask

    task automatic arm(input logic [31:0] base, input logic [2:0] en);
        en_i = '0;
        tick();
        cnt_i = base; en_i = en;
        d = (en[2] && hi) ? TPS / int'(freq_i) : DEF_D;
        tick();
        exp_cmp = base + 32'(d);
        if (en[0]) prev_v = 0;
        chk(armed_o && cmp_o == exp_cmp, "R2 arm at counter plus period", longint'(cmp_o), longint'(exp_cmp));
    endtask

    task automatic fire(input int extra, input string tag);
        logic [31:0] c0;
        bit uf, af, pf;
        logic [15:0] exp_st;
        c0 = exp_cmp;
        cnt_i = c0 + 32'(extra * d);
        tick();
        chk(busy_o == 1'b1, "R4 busy during catch-up", longint'(busy_o), 1);
        tick(extra + 1);
        exp_cmp = c0 + 32'((extra + 1) * d);
        pf = 0; uf = 0; af = 0;
        if (en_i[2]) begin
            pie += extra + 1;
            if (pie >= lim) begin pf = 1; pie = 0; end
        end
        if (en_i[0] && (!prev_v || int'(cur_ss_i) != prev_ss)) begin
            uf = prev_v; prev_ss = int'(cur_ss_i); prev_v = 1;
        end
        af = en_i[1] && ({cur_hh_i, cur_mm_i, cur_ss_i} == alm_t);
        exp_st = (uf | af | pf) ? {8'd1, 1'b1, pf, af, uf, 4'd0} : 16'd0;
        chk(busy_o == 1'b0 && cmp_o == exp_cmp, "R4 comparator after catch-up", longint'(cmp_o), longint'(exp_cmp));
        chk(lost_o == 16'(extra), "R4 R7 lost ticks", longint'(lost_o), longint'(extra));
        chk(stat_vld_o == (uf | af | pf) && status_o == exp_st, tag, longint'(status_o), longint'(exp_st));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(3);
        // R1: reset state
        chk(!armed_o && !busy_o && !stat_vld_o, "R1 reset flags", longint'({armed_o, busy_o, stat_vld_o}), 0);
        chk(cmp_o == 0 && status_o == 0 && lost_o == 0, "R1 reset values", longint'(cmp_o), 0);
        rst_n = 1'b1;
        tick();

        // R5: divide table
        for (int i = 0; i < NTBL; i++) begin
            en_i = '0; tick();
            set_freq(FREQ_TBL[i]);
            chk(lim == LIM_TBL[i], "R5 table limit", longint'(lim), longint'(LIM_TBL[i]));
            arm(32'd1000, 3'b100);
            for (int k = 0; k < LIM_TBL[i]; k++) fire(0, "R5 periodic divide status");
        end

        // R7: lost ticks credited to the periodic count
        en_i = '0; tick();
        set_freq(16);
        arm(32'd2000, 3'b100);
        fire(2, "R7 stall below limit");
        fire(0, "R7 stall completes limit");
        fire(5, "R7 stall past limit");

        // R6: high rate replaces period
        en_i = '0; tick();
        set_freq(128);
        arm(32'd5000, 3'b100);
        chk(cmp_o == 32'd5050, "R6 high-rate period", longint'(cmp_o), 5050);
        fire(0, "R6 high-rate every event");
        fire(3, "R6 high-rate after stall");

        // R8: update mode
        cur_ss_i = 6'd5;
        arm(32'd9000, 3'b001);
        fire(0, "R8 first change silent");
        fire(0, "R8 same seconds silent");
        cur_ss_i = 6'd6;
        fire(0, "R8 seconds change");
        cur_ss_i = 6'd7;
        fire(2, "R8 change after stall");

        // R9: alarm
        alm_hh_i = 5'd3; alm_mm_i = 6'd14; alm_ss_i = 6'd15; alm_wr_i = 1'b1;
        tick(); alm_wr_i = 1'b0;
        alm_t = {5'd3, 6'd14, 6'd15};
        cur_hh_i = 5'd3; cur_mm_i = 6'd14; cur_ss_i = 6'd15;
        arm(32'd12000, 3'b010);
        fire(0, "R9 alarm match");
        cur_ss_i = 6'd16;
        fire(0, "R9 alarm mismatch");

        // R3: wrap-safe compare across counter wrap
        arm(32'hFFFF_FFC0, 3'b010);
        chk(cmp_o == 32'h24, "R3 wrapped comparator", longint'(cmp_o), 32'h24);
        cnt_i = 32'hFFFF_FFF0;
        tick(3);
        chk(!busy_o && !stat_vld_o, "R3 comparator ahead across wrap", longint'(busy_o), 0);
        fire(0, "R3 match after wrap");

        // R11: disabled channel ignores counter
        en_i = '0; tick();
        chk(!armed_o, "R11 disarmed", longint'(armed_o), 0);
        cnt_i = exp_cmp + 32'd1000;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(!busy_o && !stat_vld_o && cmp_o == exp_cmp, "R11 no event when disabled",
                longint'(cmp_o), longint'(exp_cmp));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule